// File: doc/BRIEF.md
# Compare Match Timer with Prescaler

This block is one channel of a peripheral timer. A 16-bit up-counter advances on one of four slow rates derived from the peripheral clock, and a sticky match flag goes high when the counter reaches a programmable compare constant. On the tick after a match the counter restarts from zero, so the channel produces a periodic event every (compare + 1) counter steps.

Software controls the channel over a simple synchronous register bus with separate read and write strobes. Four registers are visible: a run control, a control/status word, the live counter and the compare constant. The match flag can only be cleared by writing 0 to it after it has been read back as 1. An interrupt request output mirrors the flag.

All logic runs on the single peripheral clock. The divided rates are single-cycle enable pulses from a free-running 6-bit prescale counter.

Top module: `cmt_channel`

## Requirements
- R1: After reset the counter reads 0x0000, the compare constant reads 0xFFFF, the run register reads 0x0000, the control/status register reads 0x0000 and irq is 0.
- R2: Register addresses are 0 run control, 1 control/status, 2 counter, 3 compare constant. Control/status bits 15:8 and 5:2 and run register bits 15:1 always read 0, and writing 1 to them has no effect.
- R3: Control/status bit 6 is a spare read/write bit that reads back the last value written to it.
- R4: Control/status bit 7 is the match flag. It is set at the same clock edge at which an increment makes the counter equal to the compare constant. Writing 1 to bit 7 never changes it.
- R5: A write to control/status with bit 7 = 0 clears the flag only if the flag has been read as 1 through address 1 since the last such write. Without that read, the flag stays 1.
- R6: If a flag set and an accepted clear happen in the same cycle, the flag stays 1. Any write of bit 7 = 0 disarms the clear, so a later clear needs a new read of 1.
- R7: Control/status bits 1:0 select the counter rate: 00 = clock/4, 01 = clock/8, 10 = clock/16, 11 = clock/64. The prescaler runs freely from reset, so any window of L cycles, where L is a multiple of the divisor, holds exactly L/divisor counter steps.
- R8: The counter advances only while run register bit 0 is 1. While it is 0, the counter holds its value.
- R9: On a step taken while the counter equals the compare constant, the counter goes to 0 instead of counting past it.
- R10: Writes to the counter and compare registers replace their values. irq equals the match flag at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_re | input | 1 | Read strobe; a read of the status register can arm the flag clear |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request, high while the match flag is 1 |

## Verification
The hardest situation to reach is the one where a hardware set of the flag and an armed software clear fall on the same clock edge, because the prescaler phase is not visible at the ports. The stimulus waits for irq to rise, which marks one step edge. It then uses the known divisor and compare value to count forward exactly to the next match edge, and places the clearing write so that it is taken on that edge. The divide ratios are checked over windows that are multiples of each divisor, so the result does not depend on the phase.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int ADDR_W   = 2;
    localparam int SEL_W    = 2;
    localparam int N_RATES  = 1 << SEL_W;

    localparam logic [ADDR_W-1:0] ADR_RUN  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CSR  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_CMP  = 2'd3;

    localparam int CSR_FLAG_BIT  = 7;
    localparam int CSR_SPARE_BIT = 6;

    // log2 of the divisor chosen by each rate code
    function automatic int rate_shift(input int code);
        case (code)
            0:       return 2;
            1:       return 3;
            2:       return 4;
            default: return 6;
        endcase
    endfunction

    localparam int PSC_W = 6;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    typedef struct packed {
        logic [PSC_W-1:0] psc;
    } psc_st_t;

    psc_st_t q, d;
    logic [N_RATES-1:0] tick_vec;

    generate
        for (genvar g = 0; g < N_RATES; g++) begin : g_rate
            localparam int SH = rate_shift(g);
            assign tick_vec[g] = &q.psc[SH-1:0];
        end
    endgenerate

    always_comb begin
        d     = q;
        d.psc = q.psc + 1'b1;
        tick  = tick_vec[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7: a /64 step is also a step of every faster rate
    nested_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_vec[N_RATES-1] |-> (&tick_vec));
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         match
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t q, d;

    always_comb begin
        d     = q;
        match = 1'b0;
        if (wr_en) begin
            d.cnt = wr_val;
        end else if (tick && run) begin
            d.cnt = (q.cnt == cmp) ? '0 : q.cnt + 1'b1;
            match = (d.cnt == cmp);
        end
        cnt = q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> $stable(q.cnt));

    // R9
    wrap_at_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !wr_en && q.cnt == cmp) |=> (q.cnt == '0));
endmodule

// File: rtl/cmt_flag.sv
module cmt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic rd_csr,
    input  logic clr_req,
    output logic flag
);
    typedef struct packed {
        logic flag;
        logic arm;
    } flag_st_t;

    flag_st_t q, d;

    always_comb begin
        d      = q;
        d.flag = set | (q.flag & ~(clr_req & q.arm));
        d.arm  = (q.arm & ~clr_req) | (rd_csr & q.flag);
        flag   = q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5
    hold_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !q.arm) |=> q.flag);

    // R5
    clear_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.arm && clr_req && !set) |=> !q.flag);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q.flag);

    // R6
    arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !rd_csr) |=> !q.arm);
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    typedef struct packed {
        logic             run;
        logic             spare;
        logic [SEL_W-1:0] rate;
        logic [CNT_W-1:0] cmp;
    } regs_t;

    regs_t q, d;

    logic             wr_run, wr_csr, wr_cnt, wr_cmp, rd_csr, clr_req;
    logic             tick, match, flag;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        wr_run  = bus_we && (bus_addr == ADR_RUN);
        wr_csr  = bus_we && (bus_addr == ADR_CSR);
        wr_cnt  = bus_we && (bus_addr == ADR_CNT);
        wr_cmp  = bus_we && (bus_addr == ADR_CMP);
        rd_csr  = bus_re && (bus_addr == ADR_CSR);
        clr_req = wr_csr && !bus_wdata[CSR_FLAG_BIT];

        d = q;
        if (wr_run) d.run = bus_wdata[0];
        if (wr_csr) begin
            d.spare = bus_wdata[CSR_SPARE_BIT];
            d.rate  = bus_wdata[SEL_W-1:0];
        end
        if (wr_cmp) d.cmp = bus_wdata;

        bus_rdata = '0;
        case (bus_addr)
            ADR_RUN: bus_rdata[0] = q.run;
            ADR_CSR: begin
                bus_rdata[CSR_FLAG_BIT]  = flag;
                bus_rdata[CSR_SPARE_BIT] = q.spare;
                bus_rdata[SEL_W-1:0]     = q.rate;
            end
            ADR_CNT: bus_rdata = cnt;
            default: bus_rdata = q.cmp;
        endcase
        irq = flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.cmp   <= '1;
        end else begin
            q <= d;
        end
    end

    cmt_prescaler u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (q.rate),
        .tick  (tick)
    );

    cmt_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run    (q.run),
        .wr_en  (wr_cnt),
        .wr_val (bus_wdata),
        .cmp    (q.cmp),
        .cnt    (cnt),
        .match  (match)
    );

    cmt_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (match),
        .rd_csr  (rd_csr),
        .clr_req (clr_req),
        .flag    (flag)
    );

    // R4: the flag and counter==compare appear together after a match
    match_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (flag && cnt == q.cmp));
endmodule

// File: tb/tb_cmt_channel.sv
`timescale 1ns/1ps
module tb_cmt_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    event        rd_ev;

    always #2 clk = ~clk;

    cmt_channel dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items as read data appears
    always @(rd_ev) begin
        if (exp_q.size() > 0) chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end

    // every bus task starts just after a negedge and consumes one posedge
    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
        bus_re = 1'b1; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        #1 -> rd_ev;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(input string tag);
        bit seen = 0;
        for (int i = 0; i < 400; i++) begin
            if (irq === 1'b1) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(tag, {15'd0, seen}, 16'd1);
    endtask

    function automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd2, 16'h0000, "R1 counter");
        rd(2'd3, 16'hFFFF, "R1 compare");
        rd(2'd0, 16'h0000, "R1 run");
        rd(2'd1, 16'h0000, "R1 csr");
        chk("R1 irq", {15'd0, irq}, 16'd0);

        // R2 reserved bits, R3 spare bit, R4 writing 1 to flag
        wr(2'd1, 16'hFFFF);
        rd(2'd1, 16'h0043, "R2 csr reserved/R4 flag write1");
        wr(2'd0, 16'hFFFF);
        rd(2'd0, 16'h0001, "R2 run reserved");
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0000);
        rd(2'd1, 16'h0000, "R3 spare cleared");
        wr(2'd1, 16'h0040);
        rd(2'd1, 16'h0040, "R3 spare set");
        wr(2'd1, 16'h0000);

        // R8 stopped counter holds, R10 counter write
        wr(2'd2, 16'h0005);
        idle(100);
        rd(2'd2, 16'h0005, "R8 hold stopped");

        // R7 rates over a 128-cycle window
        for (int k = 0; k < 4; k++) begin
            int sh;
            sh = (k == 3) ? 6 : k + 2;
            wr(2'd0, 16'h0000);
            wr(2'd1, 16'(k));
            wr(2'd2, 16'h0000);
            wr(2'd0, 16'h0001);
            idle(128);
            rd(2'd2, 16'(128 >> sh), $sformatf("R7 rate code %0d", k));
        end

        // R4 match, R9 wrap, R10 compare write
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0000);
        wr(2'd3, 16'h0003);
        rd(2'd3, 16'h0003, "R10 compare write");
        wr(2'd0, 16'h0001);
        wait_irq("R4 flag rises");
        rd(2'd2, 16'h0003, "R4 counter equals compare at flag");
        idle(3);
        rd(2'd2, 16'h0000, "R9 wrap to zero");

        // R5 clear protocol
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0000);
        chk("R5 unarmed clear ignored", {15'd0, irq}, 16'd1);
        rd(2'd1, 16'h0080, "R10 flag read");
        wr(2'd1, 16'h0080);
        chk("R4 write 1 no effect", {15'd0, irq}, 16'd1);
        wr(2'd1, 16'h0000);
        chk("R5 armed clear", {15'd0, irq}, 16'd0);
        rd(2'd1, 16'h0000, "R10 irq follows flag");

        // R6 set/clear collision
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h0001);
        wait_irq("R6 first match");
        rd(2'd1, 16'h0080, "R6 arm read");
        idle(14);
        wr(2'd1, 16'h0000);
        chk("R6 set wins", {15'd0, irq}, 16'd1);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0000);
        chk("R6 arm dropped", {15'd0, irq}, 16'd1);
        rd(2'd1, 16'h0080, "R6 rearm read");
        wr(2'd1, 16'h0000);
        chk("R6 clear after rearm", {15'd0, irq}, 16'd0);

        idle(2);
        summary();
        $finish;
    end
endmodule